// File: doc/BRIEF.md
# Power Button Event Handler

This block watches a raw, active-low power button line and turns it into system events. The line idles high, as if an internal pull-up held it there. It passes through a two-stage synchronizer and then through a counter-based debounce filter. A clean press then produces one of two single-cycle pulses. The sleep-request pulse goes to the interrupt logic when the system is running. The wake pulse fires when the system reports that it is asleep.

If the debounced button stays down for a long, parameterized time, the block emits a single forced-off pulse. This pulse requests an unconditional move to the soft-off state. It fires whether the system is running or in any sleep state, and it fires at most once per hold. Both the debounce time and the hold time are given in clock cycles, so simulation can use short values.

A three-state machine tracks the button. **ST_RELEASED** is the idle state. It moves to **ST_HELD** on a debounced press, and the press event is emitted on that transition. **ST_HELD** counts hold cycles. It returns to **ST_RELEASED** on a debounced release, or moves to **ST_FORCED** when the hold count reaches its limit, and the forced-off pulse is emitted on that transition. **ST_FORCED** waits for a debounced release and then returns to **ST_RELEASED**.

Top module: `pwrbtn_event_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three output pulses are low and the machine is in ST_RELEASED.
- R2: The raw input (0 = pressed) is synchronized by two flip-flops. The debounced level changes only after DEBOUNCE_CYC consecutive synchronized samples differ from it. A low excursion of DEBOUNCE_CYC-1 cycles therefore causes no event, and one of DEBOUNCE_CYC cycles causes one event.
- R3: A press with sys_asleep = 0 gives exactly one sleep_req_pulse. Counting from the clock edge after the raw line falls, the pulse is high in the cycle after edge DEBOUNCE_CYC+3.
- R4: A press with sys_asleep = 1 gives exactly one wake_pulse and no sleep_req_pulse.
- R5: Holding the button does not repeat the press event.
- R6: After HOLD_CYC cycles in ST_HELD while the button is still down, override_pulse fires once. This happens whatever sys_asleep is, and even if sys_asleep changes during the hold. It first appears in the cycle after edge DEBOUNCE_CYC+HOLD_CYC+3. A raw press of HOLD_CYC cycles gives no override, and one of HOLD_CYC+1 cycles gives one.
- R7: A raw release bounce shorter than DEBOUNCE_CYC during a hold neither restarts the hold count nor issues a second press event.
- R8: At most one of the three outputs is high in any cycle, and each pulse lasts exactly one cycle.
- R9: After a debounced release from ST_HELD or ST_FORCED, the next press is reported again as a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| btn_raw_n | input | 1 | Raw button, low = pressed, asynchronous |
| sys_asleep | input | 1 | 1 = system is in a sleep state |
| sleep_req_pulse | output | 1 | One-cycle sleep request to the interrupt logic |
| wake_pulse | output | 1 | One-cycle wake event |
| override_pulse | output | 1 | One-cycle forced soft-off request |

## Verification
Presses are tried at three lengths: just under and exactly at the debounce length, which separates a filtered glitch from a real press, and a normal press. Presses are also tried just under and just over the hold limit, which separates a plain press event from an added override. Each length is run with sys_asleep low and high to separate the sleep request from the wake event. Directed runs add a release bounce during a long hold, a change of sys_asleep mid-hold, and a press that follows an override. These show that the hold count survives bounces and that the machine re-arms after release.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
    typedef enum logic [1:0] {
        ST_RELEASED = 2'd0,
        ST_HELD     = 2'd1,
        ST_FORCED   = 2'd2
    } pb_state_t;
endpackage

// File: rtl/pbe_sync.sv
module pbe_sync #(
    parameter int      STAGES = 2,
    parameter logic    IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pbe_filter.sv
module pbe_filter #(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_n,
    output logic level_n
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_n <= 1'b1;
            run_cnt <= '0;
        end else if (smp_n == level_n) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(DEB_CYC - 1)) begin
            level_n <= smp_n;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pbe_fsm.sv
module pbe_fsm
    import pbe_pkg::*;
#(
    parameter int HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic down,
    input  logic asleep,
    output logic sleep_evt,
    output logic wake_evt,
    output logic force_evt
);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    pb_state_t state_q, state_d;
    logic [HW-1:0] hold_cnt;
    logic hold_done;

    assign hold_done = (hold_cnt == HW'(HOLD_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELEASED: if (down) state_d = ST_HELD;
            ST_HELD: begin
                if (!down)         state_d = ST_RELEASED;
                else if (hold_done) state_d = ST_FORCED;
            end
            ST_FORCED:   if (!down) state_d = ST_RELEASED;
            default:     state_d = ST_RELEASED;
        endcase
    end

    // state register and hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RELEASED;
            hold_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HELD && down && !hold_done) hold_cnt <= hold_cnt + 1'b1;
            else                                          hold_cnt <= '0;
        end
    end

    // registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_evt <= 1'b0;
            wake_evt  <= 1'b0;
            force_evt <= 1'b0;
        end else begin
            sleep_evt <= (state_q == ST_RELEASED) && down && !asleep;
            wake_evt  <= (state_q == ST_RELEASED) && down &&  asleep;
            force_evt <= (state_q == ST_HELD) && down && hold_done;
        end
    end
endmodule

// File: rtl/pwrbtn_event_unit.sv
module pwrbtn_event_unit #(
    parameter int DEBOUNCE_CYC = 1_600_000,
    parameter int HOLD_CYC     = 400_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw_n,
    input  logic sys_asleep,
    output logic sleep_req_pulse,
    output logic wake_pulse,
    output logic override_pulse
);
    logic btn_sync_n;
    logic btn_level_n;
    logic btn_down;

    pbe_sync #(.STAGES(2), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(btn_raw_n), .q_sync(btn_sync_n)
    );

    pbe_filter #(.DEB_CYC(DEBOUNCE_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .smp_n(btn_sync_n), .level_n(btn_level_n)
    );

    assign btn_down = ~btn_level_n;

    pbe_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .down(btn_down), .asleep(sys_asleep),
        .sleep_evt(sleep_req_pulse), .wake_evt(wake_pulse), .force_evt(override_pulse)
    );
endmodule

// File: rtl/pbe_checker.sv
module pbe_checker (
    input logic clk,
    input logic rst_n,
    input logic sys_asleep,
    input logic btn_down,
    input logic sleep_req_pulse,
    input logic wake_pulse,
    input logic override_pulse
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sleep_req_pulse, wake_pulse, override_pulse}));

    a_r8_sleep_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_pulse |=> !sleep_req_pulse);

    a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    a_r8_ovr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        override_pulse |=> !override_pulse);

    a_r3_sleep_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_pulse |-> $past(!sys_asleep && btn_down));

    a_r4_wake_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(sys_asleep && btn_down));

    a_r6_ovr_while_down: assert property (@(posedge clk) disable iff (!rst_n)
        override_pulse |-> $past(btn_down));

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !(sleep_req_pulse || wake_pulse || override_pulse));
endmodule

bind pwrbtn_event_unit pbe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sys_asleep(sys_asleep), .btn_down(btn_down),
    .sleep_req_pulse(sleep_req_pulse), .wake_pulse(wake_pulse),
    .override_pulse(override_pulse)
);

// File: tb/tb_pwrbtn_event_unit.sv
`timescale 1ns/1ps
module tb_pwrbtn_event_unit;
    localparam int DEB  = 4;
    localparam int HOLD = 20;
    localparam int NV   = 8;

    // {asleep, raw low length[7:0], exp sleep[1:0], exp wake[1:0], exp ovr[1:0]}
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 8'd10, 2'd1, 2'd0, 2'd0},  // R3 plain press awake
        {1'b1, 8'd10, 2'd0, 2'd1, 2'd0},  // R4 plain press asleep
        {1'b0, 8'd3,  2'd0, 2'd0, 2'd0},  // R2 glitch one short
        {1'b0, 8'd4,  2'd1, 2'd0, 2'd0},  // R2 exactly debounce
        {1'b1, 8'd60, 2'd0, 2'd1, 2'd1},  // R5 R6 long hold asleep
        {1'b0, 8'd60, 2'd1, 2'd0, 2'd1},  // R5 R6 long hold awake
        {1'b0, 8'd20, 2'd1, 2'd0, 2'd0},  // R6 hold one short
        {1'b0, 8'd21, 2'd1, 2'd0, 2'd1}   // R6 hold just enough
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw_n = 1'b1;
    logic sys_asleep = 1'b0;
    logic sleep_req_pulse, wake_pulse, override_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int c_sleep, c_wake, c_ovr, c_multi, f_sleep, f_ovr;

    always #5 clk = ~clk;

    pwrbtn_event_unit #(.DEBOUNCE_CYC(DEB), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_raw_n), .sys_asleep(sys_asleep),
        .sleep_req_pulse(sleep_req_pulse), .wake_pulse(wake_pulse),
        .override_pulse(override_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // raw low for len cycles; optional asleep flip and 2-cycle bounce
    task automatic press(input bit asleep, input int len, input int flip_at, input int bounce_at);
        c_sleep = 0; c_wake = 0; c_ovr = 0; c_multi = 0; f_sleep = 0; f_ovr = 0;
        @(negedge clk);
        sys_asleep = asleep;
        btn_raw_n  = 1'b0;
        for (int i = 1; i <= len + 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sleep_req_pulse) begin c_sleep++; if (f_sleep == 0) f_sleep = i; end
            if (wake_pulse) begin c_wake++; if (f_sleep == 0) f_sleep = i; end
            if (override_pulse) begin c_ovr++; if (f_ovr == 0) f_ovr = i; end
            if (int'(sleep_req_pulse) + int'(wake_pulse) + int'(override_pulse) > 1) c_multi++;
            if (i == flip_at) sys_asleep = ~sys_asleep;
            if (i == bounce_at) btn_raw_n = 1'b1;
            if (bounce_at != 0 && i == bounce_at + 2) btn_raw_n = 1'b0;
            if (i == len) btn_raw_n = 1'b1;
        end
        chk(c_multi == 0, "R8 overlap", c_multi, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state, button held low during reset
        btn_raw_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({sleep_req_pulse, wake_pulse, override_pulse} == 3'b000, "R1 in reset",
            int'({sleep_req_pulse, wake_pulse, override_pulse}), 0);
        btn_raw_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk({sleep_req_pulse, wake_pulse, override_pulse} == 3'b000, "R1 after reset",
            int'({sleep_req_pulse, wake_pulse, override_pulse}), 0);

        for (int v = 0; v < NV; v++) begin
            press(VEC[v][14], int'(VEC[v][13:6]), 0, 0);
            chk(c_sleep == int'(VEC[v][5:4]), $sformatf("R3 R2 sleep count vec%0d", v), c_sleep, int'(VEC[v][5:4]));
            chk(c_wake  == int'(VEC[v][3:2]), $sformatf("R4 R5 wake count vec%0d", v), c_wake, int'(VEC[v][3:2]));
            chk(c_ovr   == int'(VEC[v][1:0]), $sformatf("R6 override count vec%0d", v), c_ovr, int'(VEC[v][1:0]));
        end

        // R3 and R6 latency
        press(1'b0, 60, 0, 0);
        chk(f_sleep == DEB + 3, "R3 press latency", f_sleep, DEB + 3);
        chk(f_ovr == DEB + HOLD + 3, "R6 override latency", f_ovr, DEB + HOLD + 3);

        // R7 bounce mid-hold: no second press, hold keeps counting
        press(1'b0, 23, 0, 10);
        chk(c_sleep == 1, "R7 bounce no re-press", c_sleep, 1);
        chk(c_ovr == 1, "R7 hold not restarted", c_ovr, 1);

        // R6 sys_asleep flips mid-hold, override still fires
        press(1'b0, 40, 12, 0);
        chk(c_ovr == 1, "R6 override across flip", c_ovr, 1);
        chk(c_wake == 0, "R6 no wake from flip", c_wake, 0);

        // R9 press after forced state re-arms
        press(1'b1, 60, 0, 0);
        press(1'b1, 10, 0, 0);
        chk(c_wake == 1, "R9 re-armed wake", c_wake, 1);
        chk(c_ovr == 0, "R9 no stale override", c_ovr, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule